// File: doc/BRIEF.md
# Accelerator Slot Wrapper with Flag Handshake and Streaming

This block puts one processing kernel behind a small host-facing socket. The host configures it through a write-only register space. The host sees its state through a read-only register space. A host-written input memory carries the samples, and a host-read output memory returns the results. The kernel shown here is a per-sample scale-and-offset transform: each 8-bit input sample is multiplied by a 4-bit gain, and an 8-bit offset is added, giving a 12-bit result.

Two ways of working are offered. In block mode, the host fills the 64-entry input memory by address, then pulses a start bit. The block walks the whole block at one sample per clock and raises a sticky finish flag. The host either polls that flag or enables it onto an interrupt line. In streaming mode, both memories act as 64-deep FIFOs. A sample is processed whenever the input FIFO holds data and the output FIFO has room, and the block stalls without losing anything when the output side is full. Gain and offset are read live, so the host refreshes them as often as it likes, for example once per frame.

Top module: `accel_slot`

## Requirements
- R1: After reset the status register (read address 0) reads zero, `irq` is low, and read address 1 returns the `KERNEL_ID` parameter.
- R2: In block mode, writing 1 to bit 0 of control address 0 while idle starts a job. For every index i from 0 to 63, output entry i becomes (in[i] * gain + offset) mod 4096, where gain is bits [3:0] and offset is bits [15:8] of control address 2. The finish flag (status bit 1) is first seen set exactly 65 cycles after the clock edge that captured the start write, and busy (status bit 0) is high from the edge after that capture until that point.
- R3: A start write received while busy is ignored, so the running job's finish timing is unchanged. It sets the sticky overrun flag (status bit 2), which clears only when 1 is written to bit 2 of control address 0.
- R4: The finish flag stays set until 1 is written to bit 1 of control address 0.
- R5: `irq` equals the finish flag ANDed with the interrupt enable (bit 0 of control address 1). With the enable at 0 (poll mode), `irq` stays low while finish is set.
- R6: Status bits [14:8] give the number of results held in the output memory. This is 64 after a block job. Status bits [22:16] give the input FIFO fill level.
- R7: With bit 1 of control address 1 set (streaming), input writes push into a FIFO and the address is ignored. `out_rd_data` shows the oldest result, and `out_rd_en` pops it. Results leave in the order their samples entered.
- R8: In streaming mode, when the output FIFO holds 64 results, no input sample is consumed. After pops free space, the held samples are processed with none lost.
- R9: A start write in streaming mode has no effect: busy and finish stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_addr | input | 2 | Control register address (0 command, 1 mode, 2 parameters) |
| ctl_wr_data | input | 32 | Control register write data |
| sts_rd_addr | input | 2 | Status register address (0 status, 1 kernel id) |
| sts_rd_data | output | 32 | Status register read data, combinational |
| in_wr_en | input | 1 | Input memory write / FIFO push |
| in_wr_addr | input | 6 | Input memory address (block mode only) |
| in_wr_data | input | 8 | Input sample |
| out_rd_en | input | 1 | Output FIFO pop (streaming mode only) |
| out_rd_addr | input | 6 | Output memory address (block mode only) |
| out_rd_data | output | 12 | Output result, combinational |
| irq | output | 1 | Completion interrupt |

## Verification
A control write takes effect at the edge that captures it, and status, `irq` and output data are combinational views of registers. The bench drives on falling edges and samples one time unit later, so every value it reads reflects the most recent rising edge. The finish latency is measured against a free-running edge counter, and the bench requires a count of 65 edges after the capturing edge. It also checks that the flag is still clear one edge earlier. In streaming mode, a result appears two edges after its push and a pop takes effect at the next edge, so the bench waits several idle cycles before it reads fill levels and reads a popped head only after the following edge.

// File: rtl/accel_slot_pkg.sv
package accel_slot_pkg;

   // control (host-writable) register addresses
   localparam logic [1:0] CA_CMD   = 2'd0;
   localparam logic [1:0] CA_MODE  = 2'd1;
   localparam logic [1:0] CA_PARAM = 2'd2;

   // command bits
   localparam int CMD_START   = 0;
   localparam int CMD_CLR_FIN = 1;
   localparam int CMD_CLR_OVR = 2;

   // mode bits
   localparam int MODE_IRQ    = 0;
   localparam int MODE_STREAM = 1;

   // parameter register fields
   localparam int PRM_GAIN_LSB = 0;
   localparam int PRM_OFS_LSB  = 8;

   // status (host-readable) register addresses and fields
   localparam logic [1:0] SA_STATUS = 2'd0;
   localparam logic [1:0] SA_ID     = 2'd1;
   localparam int ST_BUSY = 0;
   localparam int ST_FIN  = 1;
   localparam int ST_OVR  = 2;
   localparam int ST_OCNT = 8;
   localparam int ST_ICNT = 16;

   typedef struct packed {
      logic stream;
      logic irq_en;
   } slot_mode_t;

endpackage

// File: rtl/slot_mem.sv
module slot_mem #(
   parameter int W     = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];

endmodule

// File: rtl/slot_kernel.sv
module slot_kernel #(
   parameter int IN_W     = 8,
   parameter int GAIN_W   = 4,
   parameter int OFS_W    = 8,
   parameter int OUT_W    = 12,
   parameter bit SATURATE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_vld,
   input  logic              in_last,
   input  logic [IN_W-1:0]   sample,
   input  logic [GAIN_W-1:0] gain,
   input  logic [OFS_W-1:0]  offset,
   output logic              out_vld,
   output logic              out_last,
   output logic [OUT_W-1:0]  result
);

   localparam int PROD_W = IN_W + GAIN_W;
   localparam int SUM_W  = ((PROD_W > OFS_W) ? PROD_W : OFS_W) + 1;
   localparam int FW     = (SUM_W > OUT_W) ? SUM_W : OUT_W;
   localparam logic [FW-1:0] MAXV = FW'((64'd1 << OUT_W) - 64'd1);

   logic [FW-1:0]    full;
   logic [OUT_W-1:0] shaped;

   assign full = FW'(sample) * FW'(gain) + FW'(offset);

   generate
      if (SATURATE) begin : g_sat
         assign shaped = (full > MAXV) ? MAXV[OUT_W-1:0] : full[OUT_W-1:0];
      end else begin : g_wrap
         assign shaped = full[OUT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_last <= 1'b0;
         result   <= '0;
      end else if (flush) begin
         out_vld  <= 1'b0;
         out_last <= 1'b0;
      end else begin
         out_vld  <= in_vld;
         out_last <= in_vld && in_last;
         if (in_vld) result <= shaped;
      end
   end

endmodule

// File: rtl/slot_regs.sv
module slot_regs
   import accel_slot_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int GAIN_W = 4,
   parameter int OFS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              busy,
   input  logic              job_done,
   output logic              start_go,
   output logic              cfg_wr,
   output slot_mode_t        mode,
   output logic [GAIN_W-1:0] gain,
   output logic [OFS_W-1:0]  offset,
   output logic              finish,
   output logic              overrun
);

   logic cmd_wr, start_req, unused_bits;

   assign cmd_wr    = wr_en && (wr_addr == CA_CMD);
   assign cfg_wr    = wr_en && (wr_addr == CA_MODE);
   assign start_req = cmd_wr && wr_data[CMD_START] && !mode.stream;
   assign start_go  = start_req && !busy;
   assign unused_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= '0;
         gain    <= '0;
         offset  <= '0;
         finish  <= 1'b0;
         overrun <= 1'b0;
      end else begin
         if (cfg_wr) begin
            mode.irq_en <= wr_data[MODE_IRQ];
            mode.stream <= wr_data[MODE_STREAM];
         end
         if (wr_en && (wr_addr == CA_PARAM)) begin
            gain   <= wr_data[PRM_GAIN_LSB +: GAIN_W];
            offset <= wr_data[PRM_OFS_LSB +: OFS_W];
         end
         if (job_done)                         finish <= 1'b1;
         else if (cmd_wr && wr_data[CMD_CLR_FIN]) finish <= 1'b0;
         if (start_req && busy)                overrun <= 1'b1;
         else if (cmd_wr && wr_data[CMD_CLR_OVR]) overrun <= 1'b0;
      end
   end

endmodule

// File: rtl/accel_slot.sv
module accel_slot
   import accel_slot_pkg::*;
#(
   parameter int          DEPTH     = 64,
   parameter int          IN_W      = 8,
   parameter int          OUT_W     = 12,
   parameter int          GAIN_W    = 4,
   parameter int          OFS_W     = 8,
   parameter int          REG_W     = 32,
   parameter bit          SATURATE  = 1'b0,
   parameter logic [31:0] KERNEL_ID = 32'h0000_0D01,
   localparam int         AW        = $clog2(DEPTH),
   localparam int         CW        = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr_en,
   input  logic [1:0]       ctl_wr_addr,
   input  logic [REG_W-1:0] ctl_wr_data,
   input  logic [1:0]       sts_rd_addr,
   output logic [REG_W-1:0] sts_rd_data,
   input  logic             in_wr_en,
   input  logic [AW-1:0]    in_wr_addr,
   input  logic [IN_W-1:0]  in_wr_data,
   input  logic             out_rd_en,
   input  logic [AW-1:0]    out_rd_addr,
   output logic [OUT_W-1:0] out_rd_data,
   output logic             irq
);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two");
      assert (CW <= 8) else $error("fill count exceeds status field");
      assert (OUT_W <= 30) else $error("OUT_W too wide");
      assert (REG_W >= ST_ICNT + CW) else $error("REG_W too narrow");
      assert (REG_W >= PRM_OFS_LSB + OFS_W) else $error("offset field out of range");
   end

   slot_mode_t        mode;
   logic [GAIN_W-1:0] gain;
   logic [OFS_W-1:0]  offset;
   logic              finish, overrun, start_go, cfg_wr, stream_on;

   logic              run, fetch_done, busy;
   logic [AW-1:0]     rd_ptr, in_wp, out_wp, out_rp;
   logic [CW-1:0]     in_cnt, out_cnt;
   logic              k_vld, k_last, job_done;
   logic [OUT_W-1:0]  k_res;
   logic [IN_W-1:0]   in_rdata;
   logic              out_room, fetch, fetch_last, in_push, out_pop;
   logic              in_we;
   logic [AW-1:0]     in_waddr, out_raddr;

   assign stream_on = mode.stream;
   assign busy      = run || k_vld;
   assign job_done  = k_vld && k_last;

   slot_regs #(.REG_W(REG_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W)) i_regs (
      .clk, .rst_n,
      .wr_en(ctl_wr_en), .wr_addr(ctl_wr_addr), .wr_data(ctl_wr_data),
      .busy, .job_done,
      .start_go, .cfg_wr, .mode, .gain, .offset, .finish, .overrun
   );

   // fetch decision
   assign out_room   = ({1'b0, out_cnt} + (CW+1)'(k_vld)) < (CW+1)'(DEPTH);
   assign fetch      = stream_on ? ((in_cnt != '0) && out_room) : (run && !fetch_done);
   assign fetch_last = !stream_on && (rd_ptr == AW'(DEPTH - 1));
   assign in_push    = stream_on && in_wr_en && (in_cnt != CW'(DEPTH));
   assign out_pop    = stream_on && out_rd_en && (out_cnt != '0);

   assign in_we     = stream_on ? in_push : in_wr_en;
   assign in_waddr  = stream_on ? in_wp   : in_wr_addr;
   assign out_raddr = stream_on ? out_rp  : out_rd_addr;

   slot_mem #(.W(IN_W), .DEPTH(DEPTH)) i_in_mem (
      .clk, .we(in_we), .waddr(in_waddr), .wdata(in_wr_data),
      .raddr(rd_ptr), .rdata(in_rdata)
   );

   slot_kernel #(
      .IN_W(IN_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .OUT_W(OUT_W), .SATURATE(SATURATE)
   ) i_kernel (
      .clk, .rst_n, .flush(cfg_wr),
      .in_vld(fetch), .in_last(fetch_last), .sample(in_rdata),
      .gain, .offset,
      .out_vld(k_vld), .out_last(k_last), .result(k_res)
   );

   slot_mem #(.W(OUT_W), .DEPTH(DEPTH)) i_out_mem (
      .clk, .we(k_vld), .waddr(out_wp), .wdata(k_res),
      .raddr(out_raddr), .rdata(out_rd_data)
   );

   // sequencing and FIFO pointers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run        <= 1'b0;
         fetch_done <= 1'b0;
         rd_ptr     <= '0;
         in_wp      <= '0;
         out_wp     <= '0;
         out_rp     <= '0;
         in_cnt     <= '0;
         out_cnt    <= '0;
      end else if (cfg_wr) begin
         run        <= 1'b0;
         fetch_done <= 1'b0;
         rd_ptr     <= '0;
         in_wp      <= '0;
         out_wp     <= '0;
         out_rp     <= '0;
         in_cnt     <= '0;
         out_cnt    <= '0;
      end else if (start_go) begin
         run        <= 1'b1;
         fetch_done <= 1'b0;
         rd_ptr     <= '0;
         out_wp     <= '0;
         out_rp     <= '0;
         out_cnt    <= '0;
      end else begin
         if (fetch) rd_ptr <= rd_ptr + 1'b1;
         if (fetch && fetch_last) fetch_done <= 1'b1;
         if (job_done) run <= 1'b0;
         if (k_vld) out_wp <= out_wp + 1'b1;
         if (out_pop) out_rp <= out_rp + 1'b1;
         out_cnt <= out_cnt + CW'(k_vld) - CW'(out_pop);
         if (in_push) in_wp <= in_wp + 1'b1;
         in_cnt <= in_cnt + CW'(in_push) - CW'(fetch && stream_on);
      end
   end

   // status view
   always_comb begin
      sts_rd_data = '0;
      case (sts_rd_addr)
         SA_STATUS: begin
            sts_rd_data[ST_BUSY]       = busy;
            sts_rd_data[ST_FIN]        = finish;
            sts_rd_data[ST_OVR]        = overrun;
            sts_rd_data[ST_OCNT +: CW] = out_cnt;
            sts_rd_data[ST_ICNT +: CW] = in_cnt;
         end
         SA_ID:   sts_rd_data = REG_W'(KERNEL_ID);
         default: sts_rd_data = '0;
      endcase
   end

   assign irq = finish && mode.irq_en;

endmodule

// File: rtl/accel_slot_chk.sv
module accel_slot_chk #(
   parameter int DEPTH = 64,
   parameter int CW    = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          run,
   input logic          stream,
   input logic          irq_en,
   input logic          cmd_start,
   input logic          cmd_clr_fin,
   input logic          ctl_wr_en,
   input logic          in_wr_en,
   input logic          overrun,
   input logic          finish,
   input logic          job_done,
   input logic          irq,
   input logic [CW-1:0] in_cnt,
   input logic [CW-1:0] out_cnt
);

   logic [CW:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   run_len <= '0;
      else if (run) run_len <= run_len + 1'b1;
      else          run_len <= '0;
   end

   // R2: a block job never stays running longer than DEPTH+1 edges
   p_job_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= (CW+1)'(DEPTH + 1));

   // R3: a start while busy in block mode raises overrun
   p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_start && !stream) |=> overrun);

   // R4: finish holds unless cleared by the host
   p_finish_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !cmd_clr_fin) |=> finish);

   // R5: a completing job with interrupts enabled drives irq next cycle
   p_done_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (job_done && irq_en && !ctl_wr_en) |=> irq);

   // R6: the output fill level never exceeds the depth
   p_out_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_cnt <= CW'(DEPTH));

   // R8: a full output FIFO consumes no input
   p_stall_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stream && out_cnt == CW'(DEPTH) && !in_wr_en && !ctl_wr_en) |=> (in_cnt == $past(in_cnt)));

endmodule

bind accel_slot accel_slot_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
   .clk(clk),
   .rst_n(rst_n),
   .busy(busy),
   .run(run),
   .stream(stream_on),
   .irq_en(mode.irq_en),
   .cmd_start(ctl_wr_en && ctl_wr_addr == 2'd0 && ctl_wr_data[0]),
   .cmd_clr_fin(ctl_wr_en && ctl_wr_addr == 2'd0 && ctl_wr_data[1]),
   .ctl_wr_en(ctl_wr_en),
   .in_wr_en(in_wr_en),
   .overrun(overrun),
   .finish(finish),
   .job_done(job_done),
   .irq(irq),
   .in_cnt(in_cnt),
   .out_cnt(out_cnt)
);

// File: tb/test_accel_slot.sv
module test_accel_slot;

   localparam int          DEPTH = 64;
   localparam logic [31:0] KID   = 32'h0000_0D01;

   // vector fields: [3:0] gain, [15:8] offset, [23:16] sample step, [31:24] sample base
   localparam logic [31:0] VECS [4] = '{
      32'h05_03_11_07, 32'h00_01_00_01, 32'hFF_FF_FF_0F, 32'h80_25_40_00
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr_en = 1'b0;
   logic [1:0]  ctl_wr_addr = '0;
   logic [31:0] ctl_wr_data = '0;
   logic [1:0]  sts_rd_addr = '0;
   logic [31:0] sts_rd_data;
   logic        in_wr_en = 1'b0;
   logic [5:0]  in_wr_addr = '0;
   logic [7:0]  in_wr_data = '0;
   logic        out_rd_en = 1'b0;
   logic [5:0]  out_rd_addr = '0;
   logic [11:0] out_rd_data;
   logic        irq;

   int cyc = 0, t_wr = 0, checks = 0, errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   accel_slot #(.KERNEL_ID(KID)) i_accel_slot (
      .clk, .rst_n, .ctl_wr_en, .ctl_wr_addr, .ctl_wr_data,
      .sts_rd_addr, .sts_rd_data, .in_wr_en, .in_wr_addr, .in_wr_data,
      .out_rd_en, .out_rd_addr, .out_rd_data, .irq
   );

   function automatic int model(int s, int g, int o);
      return (s * g + o) % 4096;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      ctl_wr_en = 1'b1; ctl_wr_addr = a; ctl_wr_data = d;
      @(negedge clk);
      ctl_wr_en = 1'b0;
      t_wr = cyc;
   endtask

   task automatic read_sts(input logic [1:0] a, output logic [31:0] d);
      sts_rd_addr = a;
      #1;
      d = sts_rd_data;
   endtask

   task automatic load_block(input int base, input int step);
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         in_wr_en = 1'b1; in_wr_addr = 6'(i); in_wr_data = 8'((base + i * step) & 255);
      end
      @(negedge clk);
      in_wr_en = 1'b0;
   endtask

   // returns edges between the start capture and the first edge with finish set
   task automatic wait_finish(input int t0, output int lat);
      logic [31:0] s;
      lat = -1;
      for (int k = 0; k < 200; k++) begin
         read_sts(2'd0, s);
         if (s[1]) begin lat = cyc - t0; break; end
         @(negedge clk);
      end
   endtask

   task automatic push_stream(input int first, input int n);
      for (int i = first; i < first + n; i++) begin
         @(negedge clk);
         in_wr_en = 1'b1; in_wr_addr = 6'd0; in_wr_data = 8'((i * 7 + 3) & 255);
      end
      @(negedge clk);
      in_wr_en = 1'b0;
   endtask

   task automatic pop_stream(input int first, input int n, input int g, input int o, output int bad);
      bad = 0;
      for (int i = first; i < first + n; i++) begin
         @(negedge clk);
         #1;
         if (int'(out_rd_data) != model((i * 7 + 3) & 255, g, o)) bad++;
         out_rd_en = 1'b1;
      end
      @(negedge clk);
      out_rd_en = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] s;
      int lat, bad, t0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      read_sts(2'd0, s);
      check(s == 32'd0, "R1 status", int'(s), 0);
      check(irq == 1'b0, "R1 irq", int'(irq), 0);
      read_sts(2'd1, s);
      check(s == KID, "R1 id", int'(s), int'(KID));

      // R2/R5/R6: table of block jobs in poll mode
      ctl_write(2'd1, 32'h0);
      foreach (VECS[v]) begin
         int g, o, base, step;
         g = int'(VECS[v][3:0]); o = int'(VECS[v][15:8]);
         step = int'(VECS[v][23:16]); base = int'(VECS[v][31:24]);
         ctl_write(2'd2, {16'h0, VECS[v][15:8], 4'h0, VECS[v][3:0]});
         load_block(base, step);
         ctl_write(2'd0, 32'h1);
         t0 = t_wr;
         read_sts(2'd0, s);
         check(s[0] == 1'b1, "R2 busy during job", int'(s[0]), 1);
         wait_finish(t0, lat);
         check(lat == 65, "R2 finish latency", lat, 65);
         check(irq == 1'b0, "R5 poll mode irq low", int'(irq), 0);
         bad = 0;
         for (int i = 0; i < DEPTH; i++) begin
            out_rd_addr = 6'(i);
            #1;
            if (int'(out_rd_data) != model((base + i * step) & 255, g, o)) bad++;
         end
         check(bad == 0, "R2 block results", bad, 0);
         read_sts(2'd0, s);
         check(s[14:8] == 7'd64 && s[0] == 1'b0, "R6 out count after job", int'(s[14:8]), 64);
         ctl_write(2'd0, 32'h2);
      end

      // R3/R4/R5: overrun, sticky finish, interrupt
      ctl_write(2'd1, 32'h1);
      ctl_write(2'd2, 32'h0000_0203);
      load_block(1, 1);
      ctl_write(2'd0, 32'h1);
      t0 = t_wr;
      repeat (10) @(negedge clk);
      ctl_write(2'd0, 32'h1);
      read_sts(2'd0, s);
      check(s[2] == 1'b1, "R3 overrun set", int'(s[2]), 1);
      repeat (60 - (cyc - t0)) @(negedge clk);
      read_sts(2'd0, s);
      check(s[1] == 1'b0, "R3 finish not early", int'(s[1]), 0);
      wait_finish(t0, lat);
      check(lat == 65, "R3 ignored start keeps timing", lat, 65);
      @(negedge clk);
      check(irq == 1'b1, "R5 irq with enable", int'(irq), 1);
      repeat (20) @(negedge clk);
      read_sts(2'd0, s);
      check(s[1] == 1'b1, "R4 finish sticky", int'(s[1]), 1);
      ctl_write(2'd0, 32'h2);
      read_sts(2'd0, s);
      check(s[1] == 1'b0 && irq == 1'b0, "R4 finish cleared", int'(s[1]), 0);
      check(s[2] == 1'b1, "R3 overrun sticky", int'(s[2]), 1);
      ctl_write(2'd0, 32'h4);
      read_sts(2'd0, s);
      check(s[2] == 1'b0, "R3 overrun cleared", int'(s[2]), 0);

      // R7/R8/R9: streaming
      ctl_write(2'd1, 32'h2);
      ctl_write(2'd2, 32'h0000_0905);
      ctl_write(2'd0, 32'h1);
      read_sts(2'd0, s);
      check(s[0] == 1'b0 && s[1] == 1'b0, "R9 start ignored in streaming", int'(s[1:0]), 0);
      push_stream(0, 64);
      repeat (6) @(negedge clk);
      read_sts(2'd0, s);
      check(s[14:8] == 7'd64 && s[22:16] == 7'd0, "R7 all samples processed", int'(s[22:8]), 64);
      push_stream(64, 5);
      repeat (6) @(negedge clk);
      read_sts(2'd0, s);
      check(s[14:8] == 7'd64 && s[22:16] == 7'd5, "R8 stalled when full", int'(s[22:16]), 5);
      pop_stream(0, 64, 5, 9, bad);
      check(bad == 0, "R7 stream order and values", bad, 0);
      repeat (6) @(negedge clk);
      read_sts(2'd0, s);
      check(s[14:8] == 7'd5 && s[22:16] == 7'd0, "R8 resumed after pops", int'(s[22:8]), 5);
      pop_stream(64, 5, 5, 9, bad);
      check(bad == 0, "R8 held samples not lost", bad, 0);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule